// File: doc/BRIEF.md
# Triggered Logic Capture Buffer

This block records eight parallel digital probe lines into an on-chip sample memory, one byte per sample. Each sample is taken either on every clock (internal timebase) or only on cycles where an external strobe from the target is high. A pattern matcher examines every sample as it arrives. Once it sees the configured event, and once enough history has been kept, capture switches from circular filling to a fixed-length post-trigger fill.

When the memory is full, the block drains it as a byte stream with a valid/ready handshake. The stream goes to a slow serial transmitter, so the host link carries no real-time burden. The stream begins with the oldest stored sample. The trigger sample lands at the position equal to the programmed pre-trigger count. After the last byte the block is idle again and can be re-armed.

Top module: `capture_buffer`

## Requirements
- R1: After reset, armed_o, triggered_o, done_o and rd_valid_o are all low.
- R2: With ext_sel_i low, a sample is taken on every clock. With ext_sel_i high, a sample is taken only on clocks where ext_strobe_i is high, and probe values on other clocks are never stored.
- R3: A sample is a trigger candidate when (probe_i & trig_mask_i) == (trig_value_i & trig_mask_i). A mask of all zeros makes every sample a candidate.
- R4: A candidate fires the trigger only if at least pre_count_i samples have been stored since arming. pre_count_i is latched when arm is accepted and must be below DEPTH.
- R5: The trigger sample is the first post-trigger sample. Capture stops after DEPTH minus the pre-trigger count post-trigger samples, so a capture whose trigger is sample t (counted from 0 after arming) takes exactly t + DEPTH - pre samples.
- R6: Readout delivers exactly DEPTH bytes, oldest first. These are the last DEPTH samples taken, and the trigger sample sits at index pre (counted from 0).
- R7: A byte transfers on a clock where rd_valid_o and rd_ready_i are both high. While rd_valid_o is high and rd_ready_i is low, rd_valid_o and rd_data_o stay unchanged.
- R8: armed_o is high while waiting for the trigger, triggered_o is high during the post-trigger fill, and done_o is high from capture end until the last byte is taken. After the last byte, all status outputs and rd_valid_o return low.
- R9: arm_i is accepted only when idle. An arm pulse during readout, including the cycle of the final byte transfer, is ignored: readout continues unaltered and armed_o stays low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| probe_i | input | 8 | Probe lines, one byte per sample |
| ext_sel_i | input | 1 | 1: sample on external strobe, 0: every clock |
| ext_strobe_i | input | 1 | External sample strobe from the target |
| trig_mask_i | input | 8 | Per-bit trigger care mask |
| trig_value_i | input | 8 | Trigger compare value |
| pre_count_i | input | $clog2(DEPTH) | Samples kept before the trigger |
| arm_i | input | 1 | Start a capture (pulse, idle only) |
| armed_o | output | 1 | Waiting for trigger |
| triggered_o | output | 1 | Post-trigger fill in progress |
| done_o | output | 1 | Capture complete, readout pending or running |
| rd_data_o | output | 8 | Readout byte |
| rd_valid_o | output | 1 | Readout byte available |
| rd_ready_i | input | 1 | Downstream accepts the byte |

## Verification
Two functions can meet in one clock: the final readout handshake and a new arm request, which the sequencer sees while still in the readout state. The bench raises arm_i in exactly the cycle it completes the last transfer. It then judges on the next cycle that armed_o is low and the stream ended with all DEPTH bytes intact. A second collision is a trigger candidate arriving before the pre-trigger history is full. The bench provokes this with a pattern that matches early, then checks from the readout contents that only the later match fired.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_TRIG,
    ST_DONE,
    ST_READ
  } cap_state_e;
endpackage

// File: rtl/cap_match.sv
module cap_match #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] smp_i,
  input  logic [NCH-1:0] mask_i,
  input  logic [NCH-1:0] value_i,
  output logic           hit_o
);
  logic [NCH-1:0] bit_ok;

  for (genvar b = 0; b < NCH; b++) begin : g_bit
    assign bit_ok[b] = ~mask_i[b] | ~(smp_i[b] ^ value_i[b]);
  end

  assign hit_o = &bit_ok;
endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int NCH   = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [AW-1:0]  waddr_i,
  input  logic [NCH-1:0] wdata_i,
  input  logic [AW-1:0]  raddr_i,
  output logic [NCH-1:0] rdata_o
);
  logic [NCH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          samp_en_i,
  input  logic          hit_i,
  input  logic [AW-1:0] pre_i,
  input  logic          rd_ready_i,
  output logic          we_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic          rd_valid_o,
  output logic          armed_o,
  output logic          triggered_o,
  output logic          done_o
);
  cap_state_e    st_q;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, pre_q, fill_q;
  logic [CW-1:0] post_q, rd_cnt_q, post_target;
  logic          capturing, fire;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign post_target = CW'(DEPTH) - {1'b0, pre_q};
  assign capturing   = (st_q == ST_ARMED) || (st_q == ST_TRIG);
  assign we_o        = capturing && samp_en_i;
  // history must be full before a candidate may fire
  assign fire        = (st_q == ST_ARMED) && samp_en_i && hit_i && (fill_q >= pre_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      pre_q    <= '0;
      fill_q   <= '0;
      post_q   <= '0;
      rd_cnt_q <= '0;
    end else begin
      if (we_o) wr_ptr_q <= nxt(wr_ptr_q);
      unique case (st_q)
        ST_IDLE: if (arm_i) begin
          st_q   <= ST_ARMED;
          pre_q  <= pre_i;
          fill_q <= '0;
        end
        ST_ARMED: if (samp_en_i) begin
          if (fire) begin
            post_q <= CW'(1);
            st_q   <= (post_target == CW'(1)) ? ST_DONE : ST_TRIG;
          end else if (fill_q < pre_q) begin
            fill_q <= fill_q + 1'b1;
          end
        end
        ST_TRIG: if (samp_en_i) begin
          post_q <= post_q + CW'(1);
          if (post_q + CW'(1) == post_target) st_q <= ST_DONE;
        end
        ST_DONE: begin
          st_q     <= ST_READ;
          rd_ptr_q <= wr_ptr_q;
          rd_cnt_q <= '0;
        end
        ST_READ: if (rd_ready_i) begin
          rd_ptr_q <= nxt(rd_ptr_q);
          rd_cnt_q <= rd_cnt_q + CW'(1);
          if (rd_cnt_q == CW'(DEPTH - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_ptr_o    = wr_ptr_q;
  assign rd_ptr_o    = rd_ptr_q;
  assign rd_valid_o  = (st_q == ST_READ);
  assign armed_o     = (st_q == ST_ARMED);
  assign triggered_o = (st_q == ST_TRIG);
  assign done_o      = (st_q == ST_DONE) || (st_q == ST_READ);

  // R9
  arm_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_READ && arm_i) |=> st_q != ST_ARMED);

  // R4
  no_early_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && !(samp_en_i && hit_i)) |=> st_q == ST_ARMED);

  // R2
  hold_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_en_i |=> $stable(wr_ptr_q));

  // R5
  post_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_TRIG |-> post_q < post_target);
endmodule

// File: rtl/capture_buffer.sv
module capture_buffer #(
  parameter int DEPTH = 16,
  parameter int NCH   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NCH-1:0]           probe_i,
  input  logic                     ext_sel_i,
  input  logic                     ext_strobe_i,
  input  logic [NCH-1:0]           trig_mask_i,
  input  logic [NCH-1:0]           trig_value_i,
  input  logic [$clog2(DEPTH)-1:0] pre_count_i,
  input  logic                     arm_i,
  output logic                     armed_o,
  output logic                     triggered_o,
  output logic                     done_o,
  output logic [NCH-1:0]           rd_data_o,
  output logic                     rd_valid_o,
  input  logic                     rd_ready_i
);
  localparam int AW = $clog2(DEPTH);

  logic          samp_en, hit, we;
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign samp_en = ext_sel_i ? ext_strobe_i : 1'b1;

  cap_match #(.NCH(NCH)) u_match (
    .smp_i   (probe_i),
    .mask_i  (trig_mask_i),
    .value_i (trig_value_i),
    .hit_o   (hit)
  );

  cap_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .samp_en_i   (samp_en),
    .hit_i       (hit),
    .pre_i       (pre_count_i),
    .rd_ready_i  (rd_ready_i),
    .we_o        (we),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .rd_valid_o  (rd_valid_o),
    .armed_o     (armed_o),
    .triggered_o (triggered_o),
    .done_o      (done_o)
  );

  cap_mem #(.NCH(NCH), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (wr_ptr),
    .wdata_i (probe_i),
    .raddr_i (rd_ptr),
    .rdata_o (rd_data_o)
  );

  // R7
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));
endmodule

// File: tb/sim_capture_buffer.sv
module sim_capture_buffer;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    probe = '0, mask = '0, value = '0;
  logic          ext_sel = 1'b0, strobe = 1'b0, arm = 1'b0, ready = 1'b0;
  logic [AW-1:0] pre = '0;
  logic          armed, trig, done, valid;
  logic [7:0]    rdata;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] log_q [0:511];
  logic [7:0] exp_q [0:DEPTH-1];
  int nlog;

  always #2 clk = ~clk;

  capture_buffer #(.DEPTH(DEPTH), .NCH(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .probe_i(probe), .ext_sel_i(ext_sel),
    .ext_strobe_i(strobe), .trig_mask_i(mask), .trig_value_i(value),
    .pre_count_i(pre), .arm_i(arm), .armed_o(armed), .triggered_o(trig),
    .done_o(done), .rd_data_o(rdata), .rd_valid_o(valid), .rd_ready_i(ready)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: act %0d exp <100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!armed && !trig && !done && !valid, "R1", "status after reset",
        {armed, trig, done, valid}, 0);
  endtask

  // arm, feed samples until done, build expected readout
  task automatic capture(input logic [7:0] m, input logic [7:0] v, input logic [7:0] base,
                         input int p, input bit ext, input int per, input string tag);
    int idx = 0, n = 0, t = -1, guard = 0;
    bit saw_trig = 0;
    @(negedge clk);
    mask = m; value = v; pre = AW'(p); ext_sel = ext; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    chk(armed == 1'b1, "R8", {tag, " armed after arm"}, armed, 1);
    while (!done && guard < 2000) begin
      if (trig) saw_trig = 1;
      strobe = ext ? ((n % per) == 0) : 1'b0;
      if (!ext || strobe) begin
        probe = base + 8'(idx);
        log_q[idx] = probe;
        idx++;
      end else begin
        probe = 8'hEE;
      end
      n++; guard++;
      @(negedge clk);
    end
    strobe = 1'b0;
    nlog = idx;
    for (int i = 0; i < nlog; i++) begin
      if (t < 0 && i >= p && ((log_q[i] ^ v) & m) == 8'h00) t = i;
    end
    chk(t >= 0, "R3", {tag, " trigger expected"}, t, 0);
    if (t < 0) t = p;
    chk(nlog == t + DEPTH - p, "R5", {tag, " capture length"}, nlog, t + DEPTH - p);
    if (DEPTH - p > 1)
      chk(saw_trig, "R8", {tag, " triggered seen"}, saw_trig, 1);
    for (int j = 0; j < DEPTH; j++) exp_q[j] = log_q[t - p + j];
  endtask

  task automatic readout(input int p, input bit arm_last, input string tag);
    int j = 0, k = 0, guard = 0;
    bit stalled = 0, bad = 0, hold_bad = 0;
    logic [7:0] held = '0;
    while (j < DEPTH && guard < 1000) begin
      ready = (k % 3) != 1;
      k++; guard++;
      if (stalled && (!valid || rdata != held)) hold_bad = 1;
      if (valid && ready) begin
        if (rdata != exp_q[j]) begin
          bad = 1;
          chk(0, "R6", {tag, " byte"}, rdata, exp_q[j]);
        end
        if (j == p) chk(rdata == exp_q[p], "R6", {tag, " trigger slot"}, rdata, exp_q[p]);
        if (arm_last && j == DEPTH - 1) arm = 1'b1;
        j++;
      end
      stalled = valid && !ready;
      held = rdata;
      @(negedge clk);
      arm = 1'b0;
    end
    ready = 1'b0;
    chk(j == DEPTH && !bad, "R6", {tag, " full ordered stream"}, j, DEPTH);
    chk(!hold_bad, "R7", {tag, " stall hold"}, hold_bad, 0);
    chk(!valid && !done && !trig, "R8", {tag, " idle after last"}, {valid, done, trig}, 0);
    if (arm_last) chk(!armed, "R9", {tag, " arm on last byte ignored"}, armed, 0);
  endtask

  task automatic t_immediate();
    capture(8'h00, 8'h00, 8'h10, 0, 1'b0, 1, "mask0");
    readout(0, 1'b0, "mask0");
  endtask

  task automatic t_pattern();
    capture(8'hF0, 8'h50, 8'h40, 5, 1'b0, 1, "pattern");
    chk(exp_q[5] == 8'h50, "R3", "pattern trigger byte", exp_q[5], 8'h50);
    readout(5, 1'b0, "pattern");
  endtask

  task automatic t_early_match();
    capture(8'h0F, 8'h02, 8'h40, 4, 1'b0, 1, "early");
    chk(exp_q[0] == 8'h4E, "R4", "early match skipped", exp_q[0], 8'h4E);
    readout(4, 1'b0, "early");
  endtask

  task automatic t_ext_strobe();
    capture(8'h00, 8'h00, 8'h80, 3, 1'b1, 3, "strobe");
    chk(exp_q[0] == 8'h80 && exp_q[DEPTH-1] == 8'h8F, "R2", "strobe samples only",
        exp_q[0], 8'h80);
    readout(3, 1'b1, "strobe");
    ext_sel = 1'b0;
  endtask

  task automatic t_max_pre();
    capture(8'h00, 8'h00, 8'h20, DEPTH - 1, 1'b0, 1, "maxpre");
    readout(DEPTH - 1, 1'b1, "maxpre");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_immediate();
    t_pattern();
    t_early_match();
    t_ext_strobe();
    t_max_pre();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule